// File: doc/BRIEF.md
# Floating-point operand expander

The block accepts one memory operand per cycle in single, double or extended precision and widens it into one internal extended form. That form has a sign, a biased exponent with bias 16383, an explicit integer bit and a 63-bit fraction. The block also reports whether the operand is a zero, a denormal, an infinity or a NaN. The result appears on the registered outputs one clock after the operand is presented.

A mode input states how the operand will be used. In arithmetic mode, denormals and extended unnormals are normalized: the mantissa is shifted left by its leading-zero count and the exponent is lowered by the same amount. An extended unnormal whose mantissa is all zeros becomes a true zero. In move mode, a denormal keeps its unshifted mantissa, because the value is only being stored in a register. The exponent is carried as a 17-bit two's-complement value, so a normalized extended denormal can go below zero without wrapping.

Top module: `fpx_expand`

## Requirements
- R1: `valid_o` follows `valid_i` with a latency of exactly one clock. While in reset, `valid_o` and all data outputs are zero.
- R2: Format code 0 is single precision, held in `opnd_i[31:0]`. A normal single (exponent field 1..254) gives `exp_o` = field + 16256, `int_o` = 1, `frac_o` = the 23 fraction bits followed by 40 zeros, and the sign unchanged.
- R3: Format code 1 is double precision, held in `opnd_i[63:0]`. A normal double gives `exp_o` = field + 15360, `int_o` = 1, `frac_o` = the 52 fraction bits followed by 11 zeros.
- R4: A single or double with a zero exponent field and a zero fraction gives `exp_o` = 0, a zero mantissa, the sign kept, and `zero_o` = 1.
- R5: An all-ones exponent field gives `exp_o` = 0x7FFF. The fraction is kept left-aligned. For single and double, `int_o` = 1. An extended input keeps its own integer bit. `inf_o` is set when the fraction bits below the integer bit are zero; otherwise `nan_o` is set.
- R6: In move mode (`arith_i` = 0), a denormal keeps its unshifted mantissa with `int_o` = 0 and sets `denorm_o`. Its exponent is 16257 for single, 15361 for double, and 0 for extended (format code 2, sign at bit 79, exponent at 78:64, mantissa at 63:0).
- R7: In arithmetic mode, a denormal is shifted left until `int_o` = 1. Its exponent is 16257, 15361 or 1 (single, double, extended) minus the shift count, and may be negative. `denorm_o` stays set.
- R8: An extended input with a non-zero, non-maximal exponent, integer bit 0 and a non-zero mantissa is normalized in arithmetic mode (exponent minus shift count). In move mode it passes through unchanged.
- R9: An extended input with a zero mantissa and a non-maximal exponent sets `zero_o`. In arithmetic mode its exponent becomes 0. In move mode its exponent is kept. The sign is kept in both modes.
- R10: An extended input with the integer bit set and a non-maximal exponent passes through unchanged in both modes, with all class flags clear. Format code 3 behaves as extended.
- R11: At most one of `zero_o`, `denorm_o`, `inf_o` and `nan_o` is set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand present this cycle |
| fmt_i | input | 2 | Input format: 0 single, 1 double, 2/3 extended |
| arith_i | input | 1 | 1 = arithmetic use (normalize), 0 = register move |
| opnd_i | input | 80 | Operand, right-aligned for single and double |
| valid_o | output | 1 | Result valid |
| sign_o | output | 1 | Sign |
| exp_o | output | 17 | Biased exponent, two's complement |
| int_o | output | 1 | Explicit integer bit |
| frac_o | output | 63 | Fraction |
| zero_o | output | 1 | Operand is zero |
| denorm_o | output | 1 | Operand is denormal |
| inf_o | output | 1 | Operand is infinity |
| nan_o | output | 1 | Operand is NaN |

## Verification
The hardest case to reach is an arithmetic-mode extended denormal whose single set bit sits deep in the mantissa. This drives the exponent below zero and exercises the full 63-place shift. The stimulus targets it directly with mantissas of 1 and of a single high bit. It also sends extended unnormals with a small exponent, so that the subtraction crosses zero. Every directed operand is sent in both modes back to back, so a mode mix-up shows at once as a mismatch.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int EXP_W    = 15;
  localparam int MAN_W    = 64;
  localparam int XE_W     = EXP_W + 2;
  localparam int OP_W     = 1 + EXP_W + MAN_W;
  localparam int XBIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int XEMAX    = (1 << EXP_W) - 1;
  localparam int LZC_W    = $clog2(MAN_W) + 1;
  localparam int SGL_E_W  = 8;
  localparam int SGL_F_W  = 23;
  localparam int DBL_E_W  = 11;
  localparam int DBL_F_W  = 52;

  typedef enum logic [1:0] {
    FMT_SGL = 2'd0,
    FMT_DBL = 2'd1,
    FMT_EXT = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;

  typedef struct packed {
    logic                   sign;
    logic signed [XE_W-1:0] exp;
    logic [MAN_W-1:0]       man;
    logic                   zero;
    logic                   denorm;
    logic                   inf;
    logic                   nan;
  } xop_t;
endpackage

// File: rtl/fpx_ieee_widen.sv
module fpx_ieee_widen
  import fpx_pkg::*;
#(
  parameter int E_W = 8,
  parameter int F_W = 23
) (
  input  logic [E_W+F_W:0]       bits_i,
  output xop_t                   x_o,
  output logic signed [XE_W-1:0] eff_exp_o
);
  localparam int EMAX    = (1 << E_W) - 1;
  localparam int BIAS_IN = (1 << (E_W - 1)) - 1;
  localparam int REBIAS  = XBIAS - BIAS_IN;
  localparam int PAD     = MAN_W - 1 - F_W;

  logic [E_W-1:0] be;
  logic [F_W-1:0] fr;
  logic           fnz;

  assign be        = bits_i[E_W+F_W-1:F_W];
  assign fr        = bits_i[F_W-1:0];
  assign fnz       = |fr;
  // denormal value exponent equals that of the smallest normal
  assign eff_exp_o = XE_W'(REBIAS + 1);

  always_comb begin
    x_o      = '0;
    x_o.sign = bits_i[E_W+F_W];
    x_o.man  = {1'b0, fr, {PAD{1'b0}}};
    if (be == E_W'(EMAX)) begin
      x_o.exp            = XE_W'(XEMAX);
      x_o.man[MAN_W-1]   = 1'b1;
      x_o.inf            = ~fnz;
      x_o.nan            = fnz;
    end else if (be == '0) begin
      if (fnz) begin
        x_o.denorm = 1'b1;
        x_o.exp    = XE_W'(REBIAS + 1);
      end else begin
        x_o.zero   = 1'b1;
      end
    end else begin
      x_o.exp          = XE_W'(be) + XE_W'(REBIAS);
      x_o.man[MAN_W-1] = 1'b1;
    end
  end
endmodule

// File: rtl/fpx_unpack.sv
module fpx_unpack
  import fpx_pkg::*;
(
  input  logic [1:0]             fmt_i,
  input  logic [OP_W-1:0]        opnd_i,
  output xop_t                   pre_o,
  output logic signed [XE_W-1:0] eff_exp_o
);
  xop_t                   ieee_x   [2];
  logic signed [XE_W-1:0] ieee_eff [2];

  for (genvar g = 0; g < 2; g++) begin : g_ieee
    localparam int E = (g == 0) ? SGL_E_W : DBL_E_W;
    localparam int F = (g == 0) ? SGL_F_W : DBL_F_W;
    fpx_ieee_widen #(.E_W(E), .F_W(F)) u_widen (
      .bits_i    (opnd_i[E+F:0]),
      .x_o       (ieee_x[g]),
      .eff_exp_o (ieee_eff[g])
    );
  end

  logic [EXP_W-1:0]       xe;
  logic [MAN_W-1:0]       xm;
  xop_t                   ext_x;
  logic signed [XE_W-1:0] ext_eff;

  assign xe = opnd_i[OP_W-2 -: EXP_W];
  assign xm = opnd_i[MAN_W-1:0];

  always_comb begin
    ext_x      = '0;
    ext_x.sign = opnd_i[OP_W-1];
    ext_x.exp  = XE_W'(xe);
    ext_x.man  = xm;
    ext_eff    = XE_W'(xe);
    if (xe == EXP_W'(XEMAX)) begin
      ext_x.inf = ~|xm[MAN_W-2:0];
      ext_x.nan = |xm[MAN_W-2:0];
    end else if (xm == '0) begin
      ext_x.zero = 1'b1;
    end else if (xe == '0 && !xm[MAN_W-1]) begin
      ext_x.denorm = 1'b1;
      ext_eff      = XE_W'(1);
    end
  end

  always_comb begin
    case (fmt_e'(fmt_i))
      FMT_SGL: begin pre_o = ieee_x[0]; eff_exp_o = ieee_eff[0]; end
      FMT_DBL: begin pre_o = ieee_x[1]; eff_exp_o = ieee_eff[1]; end
      default: begin pre_o = ext_x;     eff_exp_o = ext_eff;     end
    endcase
  end
endmodule

// File: rtl/fpx_lzc.sv
module fpx_lzc #(
  parameter int W  = 64,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  // highest set bit wins
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpx_norm.sv
module fpx_norm
  import fpx_pkg::*;
(
  input  xop_t                   pre_i,
  input  logic signed [XE_W-1:0] eff_exp_i,
  input  logic                   arith_i,
  output xop_t                   res_o
);
  logic [LZC_W-1:0] lz;
  logic             cand;

  fpx_lzc #(.W(MAN_W)) u_lzc (
    .vec_i (pre_i.man),
    .cnt_o (lz)
  );

  assign cand = !pre_i.man[MAN_W-1] && (|pre_i.man) && !pre_i.inf && !pre_i.nan;

  always_comb begin
    res_o = pre_i;
    if (arith_i) begin
      if (pre_i.zero) begin
        res_o.exp = '0;
      end else if (cand) begin
        res_o.man = pre_i.man << lz;
        res_o.exp = eff_exp_i - $signed(XE_W'(lz));
      end
    end
  end
endmodule

// File: rtl/fpx_expand.sv
module fpx_expand
  import fpx_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [1:0]             fmt_i,
  input  logic                   arith_i,
  input  logic [OP_W-1:0]        opnd_i,
  output logic                   valid_o,
  output logic                   sign_o,
  output logic signed [XE_W-1:0] exp_o,
  output logic                   int_o,
  output logic [MAN_W-2:0]       frac_o,
  output logic                   zero_o,
  output logic                   denorm_o,
  output logic                   inf_o,
  output logic                   nan_o
);
  xop_t                   pre, res, res_q;
  logic signed [XE_W-1:0] eff_exp;
  logic                   valid_q;

  fpx_unpack u_unpack (
    .fmt_i     (fmt_i),
    .opnd_i    (opnd_i),
    .pre_o     (pre),
    .eff_exp_o (eff_exp)
  );

  fpx_norm u_norm (
    .pre_i     (pre),
    .eff_exp_i (eff_exp),
    .arith_i   (arith_i),
    .res_o     (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= res;
    end
  end

  assign valid_o  = valid_q;
  assign sign_o   = res_q.sign;
  assign exp_o    = res_q.exp;
  assign int_o    = res_q.man[MAN_W-1];
  assign frac_o   = res_q.man[MAN_W-2:0];
  assign zero_o   = res_q.zero;
  assign denorm_o = res_q.denorm;
  assign inf_o    = res_q.inf;
  assign nan_o    = res_q.nan;
endmodule

// File: rtl/fpx_expand_chk.sv
module fpx_expand_chk
  import fpx_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   valid_i,
  input logic [1:0]             fmt_i,
  input logic                   arith_i,
  input logic                   valid_o,
  input logic signed [XE_W-1:0] exp_o,
  input logic                   int_o,
  input logic [MAN_W-2:0]       frac_o,
  input logic                   zero_o,
  input logic                   denorm_o,
  input logic                   inf_o,
  input logic                   nan_o
);
  logic       v_q, a_q;
  logic [1:0] f_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0;
      a_q <= 1'b0;
      f_q <= '0;
    end else begin
      v_q <= valid_i;
      a_q <= arith_i;
      f_q <= fmt_i;
    end
  end

  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v_q);

  // R11
  class_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $onehot0({zero_o, denorm_o, inf_o, nan_o}));

  // R5
  special_exp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (inf_o || nan_o)) |-> exp_o == XE_W'(XEMAX));

  // R5
  inf_frac_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && inf_o) |-> frac_o == '0);

  // R9
  zero_man_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && zero_o) |-> (!int_o && frac_o == '0));

  // R7
  arith_denorm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && denorm_o && a_q) |-> int_o);

  // R6
  move_denorm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && denorm_o && !a_q) |-> !int_o);

  // R2
  sgl_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && f_q == 2'd0 && !zero_o && !denorm_o) |-> int_o);
endmodule

bind fpx_expand fpx_expand_chk u_chk (.*);

// File: tb/sim_fpx_expand.sv
module sim_fpx_expand;
  import fpx_pkg::*;

  localparam int CLK_P = 10;

  logic                   clk = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   valid_i = 1'b0;
  logic [1:0]             fmt_i = '0;
  logic                   arith_i = 1'b0;
  logic [OP_W-1:0]        opnd_i = '0;
  logic                   valid_o, sign_o, int_o, zero_o, denorm_o, inf_o, nan_o;
  logic signed [XE_W-1:0] exp_o;
  logic [MAN_W-2:0]       frac_o;

  always #(CLK_P/2) clk = ~clk;

  fpx_expand u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .fmt_i(fmt_i),
    .arith_i(arith_i), .opnd_i(opnd_i), .valid_o(valid_o), .sign_o(sign_o),
    .exp_o(exp_o), .int_o(int_o), .frac_o(frac_o), .zero_o(zero_o),
    .denorm_o(denorm_o), .inf_o(inf_o), .nan_o(nan_o)
  );

  typedef struct {
    logic        s;
    int          e;
    logic [63:0] m;
    logic        z, d, i, n;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  function automatic item_t ref_model(logic [1:0] fmt, logic arith, logic [79:0] op);
    item_t r;
    int    eb, fb, be, rb;
    logic [63:0] fr;
    r.z = 0; r.d = 0; r.i = 0; r.n = 0; r.m = '0; r.e = 0;
    if (fmt == 2'd0 || fmt == 2'd1) begin
      eb = (fmt == 2'd0) ? 8 : 11;
      fb = (fmt == 2'd0) ? 23 : 52;
      r.s = op[eb+fb];
      be = int'((op >> fb) & ((80'd1 << eb) - 1));
      fr = 64'(op & ((80'd1 << fb) - 1));
      rb = 16383 - ((1 << (eb - 1)) - 1);
      r.m = fr << (63 - fb);
      if (be == (1 << eb) - 1) begin
        r.e = 32767; r.m[63] = 1'b1;
        if (fr == 0) r.i = 1; else r.n = 1;
        r.tag = "R5";
      end else if (be == 0 && fr == 0) begin
        r.z = 1; r.tag = "R4";
      end else if (be == 0) begin
        r.d = 1; r.e = rb + 1;
        r.tag = arith ? "R7" : "R6";
        if (arith) while (!r.m[63]) begin r.m = r.m << 1; r.e = r.e - 1; end
      end else begin
        r.e = be + rb; r.m[63] = 1'b1;
        r.tag = (fmt == 2'd0) ? "R2" : "R3";
      end
    end else begin
      r.s = op[79];
      be  = int'(op[78:64]);
      r.m = op[63:0];
      r.e = be;
      if (be == 32767) begin
        if (r.m[62:0] == 0) r.i = 1; else r.n = 1;
        r.tag = "R5";
      end else if (r.m == 0) begin
        r.z = 1; r.tag = "R9";
        if (arith) r.e = 0;
      end else if (be == 0 && !r.m[63]) begin
        r.d = 1; r.tag = arith ? "R7" : "R6";
        if (arith) begin
          r.e = 1;
          while (!r.m[63]) begin r.m = r.m << 1; r.e = r.e - 1; end
        end
      end else if (!r.m[63]) begin
        r.tag = "R8";
        if (arith) while (!r.m[63]) begin r.m = r.m << 1; r.e = r.e - 1; end
      end else begin
        r.tag = "R10";
      end
    end
    return r;
  endfunction

  task automatic drive(logic [1:0] fmt, logic arith, logic [79:0] op);
    @(negedge clk);
    fmt_i = fmt; arith_i = arith; opnd_i = op; valid_i = 1'b1;
    sb_q.push_back(ref_model(fmt, arith, op));
  endtask

  task automatic both(logic [1:0] fmt, logic [79:0] op);
    drive(fmt, 1'b0, op);
    drive(fmt, 1'b1, op);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    valid_i = 1'b0;
    for (int k = 1; k < n; k++) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (valid_o) begin
        n_chk++;
        if (sb_q.size() == 0) begin
          n_fail++;
          $display("FAIL R1 valid_o=1 expected 0 (no pending item)");
        end else begin
          item_t x;
          x = sb_q.pop_front();
          if (sign_o !== x.s || int'(exp_o) != x.e || {int_o, frac_o} !== x.m ||
              {zero_o, denorm_o, inf_o, nan_o} !== {x.z, x.d, x.i, x.n}) begin
            n_fail++;
            $display("FAIL %s R11 act s=%b e=%0d m=%h f=%b%b%b%b exp s=%b e=%0d m=%h f=%b%b%b%b",
                     x.tag, sign_o, int'(exp_o), {int_o, frac_o}, zero_o, denorm_o, inf_o, nan_o,
                     x.s, x.e, x.m, x.z, x.d, x.i, x.n);
          end
        end
      end
    end
  end

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired, queue=%0d expected 0", sb_q.size());
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    n_chk++;
    if (valid_o !== 1'b0 || exp_o !== '0 || frac_o !== '0 || int_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset valid=%b exp=%0d frac=%h expected 0", valid_o, exp_o, frac_o);
    end
    rst_ni = 1'b1;
    @(negedge clk);

    // single: R2 R4 R5 R6 R7
    both(2'd0, 80'h0000_0000);
    both(2'd0, 80'h8000_0000);
    both(2'd0, 80'h3F80_0000);
    both(2'd0, 80'hC020_0000);
    both(2'd0, 80'h7F7F_FFFF);
    both(2'd0, 80'h0000_0001);
    both(2'd0, 80'h8040_0000);
    both(2'd0, 80'h7F80_0000);
    both(2'd0, 80'hFF80_0000);
    both(2'd0, 80'h7FC0_0000);
    both(2'd0, 80'h7F80_0001);
    idle(3);
    // double: R3 R4 R5 R6 R7
    both(2'd1, 80'h0);
    both(2'd1, 80'h8000_0000_0000_0000);
    both(2'd1, 80'h3FF0_0000_0000_0000);
    both(2'd1, 80'h0000_0000_0000_0001);
    both(2'd1, 80'h800F_FFFF_FFFF_FFFF);
    both(2'd1, 80'h7FF0_0000_0000_0000);
    both(2'd1, 80'h7FF8_0000_0000_0000);
    both(2'd1, 80'hFFF0_0000_0000_0001);
    // extended: R5 R6 R7 R8 R9 R10
    both(2'd2, {16'h0000, 64'h0});
    both(2'd2, {16'h8000, 64'h0});
    both(2'd2, {16'h3FFF, 64'h8000_0000_0000_0000});
    both(2'd2, {16'hC00A, 64'hC123_4567_89AB_CDEF});
    both(2'd2, {16'h0000, 64'h0000_0000_0000_0001});
    both(2'd2, {16'h8000, 64'h4000_0000_0000_0000});
    both(2'd2, {16'h0005, 64'h0000_0000_0000_0001});
    both(2'd2, {16'h3FFF, 64'h0000_00F0_0000_0000});
    both(2'd2, {16'h8123, 64'h0});
    both(2'd2, {16'h7FFF, 64'h8000_0000_0000_0000});
    both(2'd2, {16'hFFFF, 64'hC000_0000_0000_0000});
    both(2'd2, {16'h7FFF, 64'h0000_0000_0000_0001});
    both(2'd2, {16'h0000, 64'h8000_0000_0000_0001});
    both(2'd3, {16'h4001, 64'hA000_0000_0000_0000});
    both(2'd3, {16'h0000, 64'h0000_0100_0000_0000});
    idle(2);
    // random normals R2 R3
    for (int k = 0; k < 40; k++) begin
      logic [31:0] sv;
      logic [63:0] dv;
      sv = {$urandom_range(1, 0) == 1, 8'($urandom_range(254, 1)), 23'($urandom)};
      dv = {$urandom_range(1, 0) == 1, 11'($urandom_range(2046, 1)), 20'($urandom), 32'($urandom)};
      drive(2'd0, 1'($urandom), {48'h0, sv});
      drive(2'd1, 1'($urandom), {16'h0, dv});
    end
    idle(4);
    n_chk++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1 pending items=%0d expected 0", sb_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule